// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits at the command-register front end of a byte-wide parallel NOR flash model. Every bus write reaches it as one clocked event that carries a 19-bit address and a data byte. The block follows the keyed multi-write sequences a host uses to choose an operation. When a sequence completes it sends a one-cycle request to the operation controller downstream. A request carries an operation code, and also the address and data of the write that completed the sequence.

The operation controller reports its own activity back through three inputs. One says a byte program is running, one says a sector erase is running, and one says an erase is suspended. The decoder uses these inputs to limit which writes it acts on. The block also holds the silicon-ID flag, and while that flag is set it drives the identification byte onto a small readback mux.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, no request is issued, `id_active` is 0, `id_data` is 00h, and the decoder waits for the first write of a sequence.
- R2: Key cycles compare only address bits [10:0] against 555h and 2AAh. Bits [18:11] of a key cycle have no effect.
- R3: The writes AAh@555h, 55h@2AAh, A0h@555h and then any write issue a program request (`req_op`=2). The request carries the full address and data of that fourth write. The fourth write is always taken as data, even when it is F0h.
- R4: The writes AAh@555h, 55h@2AAh, 90h@555h issue an ID request (`req_op`=1) and set `id_active`. While the flag is set, `rd_addr`=0 gives C2h, `rd_addr`=1 gives 45h (46h when `BOTTOM_BOOT`=1), and `rd_addr`=2 or 3 gives 00h. Any later accepted write clears the flag.
- R5: The sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh followed by 10h@555h issues chip erase (`req_op`=3). The same five writes followed by 20h@555h issue protect-unlock (`req_op`=7).
- R6: The same five-write prefix followed by 30h at any address issues sector erase (`req_op`=4). The request carries the full 19-bit address of that sixth write.
- R7: F0h at any address, in any cycle except the program data cycle, returns the decoder to the first cycle. Outside suspend it issues a read/reset request (`req_op`=0).
- R8: A write with the wrong address or data for the current cycle returns the decoder to the first cycle without a request. The following write is decoded as the first cycle of a new sequence.
- R9: While `prog_busy` is 1, every write is ignored. No request is issued and the partial sequence and `id_active` are kept.
- R10: While `erase_busy` is 1 and `prog_busy` is 0, only B0h at any address is acted on, and it issues suspend (`req_op`=5). All other writes are ignored.
- R11: B0h and 30h written as first-cycle writes outside the erase-busy and suspended states issue no request.
- R12: While `suspended` is 1 and neither busy input is 1, 30h as a first-cycle write issues resume (`req_op`=6). Program sequences are accepted. Sequences with 80h or 90h in the third cycle are dropped without a request, and F0h issues no request.
- R13: `req_valid` is high for exactly the one cycle after the clock edge that samples the write that completes a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle bus write event |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | 8 | Data of the write |
| prog_busy | input | 1 | Program operation in progress |
| erase_busy | input | 1 | Sector erase in progress and not suspended |
| suspended | input | 1 | Erase is suspended |
| rd_addr | input | 2 | Low read address bits for the ID mux |
| req_valid | output | 1 | One-cycle request strobe |
| req_op | output | 3 | Requested operation code |
| req_addr | output | ADDR_W | Address of the completing write |
| req_data | output | 8 | Data of the completing write |
| id_active | output | 1 | Silicon-ID mode flag |
| id_data | output | 8 | Identification byte, 00h when the flag is clear |

## Verification
The hardest case to reach is a partial sequence that must survive a stretch of ignored writes. The bench drives AAh@555h, raises `prog_busy`, and writes junk including F0h. It then drops `prog_busy` and finishes the program sequence, so a request appears only if the partial state was kept. The suspend state is handled the same way. The bench holds `suspended` high and drives program, erase-setup and ID sequences, which shows that the third-cycle restrictions apply only in that state.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
   localparam int BYTE_W = 8;
   localparam int KEY_W  = 11;

   typedef enum logic [2:0] {
      OP_READ       = 3'd0,
      OP_ID         = 3'd1,
      OP_PROG       = 3'd2,
      OP_CHIP_ERASE = 3'd3,
      OP_SECT_ERASE = 3'd4,
      OP_SUSPEND    = 3'd5,
      OP_RESUME     = 3'd6,
      OP_UNLOCK     = 3'd7
   } op_e;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_U1, SQ_U2, SQ_PD, SQ_E0, SQ_E1, SQ_E2
   } seq_e;

   localparam logic [KEY_W-1:0]  KEY_ADDR_A = 11'h555;
   localparam logic [KEY_W-1:0]  KEY_ADDR_B = 11'h2AA;
   localparam logic [BYTE_W-1:0] K_KEY_A    = 8'hAA;
   localparam logic [BYTE_W-1:0] K_KEY_B    = 8'h55;
   localparam logic [BYTE_W-1:0] K_PROG     = 8'hA0;
   localparam logic [BYTE_W-1:0] K_IDENT    = 8'h90;
   localparam logic [BYTE_W-1:0] K_ERASE    = 8'h80;
   localparam logic [BYTE_W-1:0] K_CHIP     = 8'h10;
   localparam logic [BYTE_W-1:0] K_SECTOR   = 8'h30;
   localparam logic [BYTE_W-1:0] K_PROTECT  = 8'h20;
   localparam logic [BYTE_W-1:0] K_RESET    = 8'hF0;
   localparam logic [BYTE_W-1:0] K_SUSPEND  = 8'hB0;
   localparam logic [BYTE_W-1:0] K_RESUME   = 8'h30;
   localparam logic [BYTE_W-1:0] ID_MAKER   = 8'hC2;
   localparam logic [BYTE_W-1:0] ID_DEV_TOP = 8'h45;
   localparam logic [BYTE_W-1:0] ID_DEV_BOT = 8'h46;
endpackage

// File: rtl/fcd_gate.sv
module fcd_gate
   import fcd_pkg::*;
(
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              prog_busy,
   input  logic              erase_busy,
   input  logic              suspended,
   output logic              seq_we,
   output logic              susp_fire,
   output logic              restricted
);
   // Priority: program busy, then erase busy, then suspended.
   always_comb begin
      seq_we     = wr_en && !prog_busy && !erase_busy;
      susp_fire  = wr_en && !prog_busy && erase_busy && (wr_data == K_SUSPEND);
      restricted = suspended && !erase_busy;
   end
endmodule

// File: rtl/fcd_sequencer.sv
module fcd_sequencer
   import fcd_pkg::*;
#(
   parameter int ADDR_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seq_we,
   input  logic              restricted,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic              hit,
   output op_e               hit_op,
   output logic              id_mode
);
   seq_e state, nxt;
   logic id_set;
   logic at_a, at_b;

   always_comb begin
      at_a   = (wr_addr[KEY_W-1:0] == KEY_ADDR_A);
      at_b   = (wr_addr[KEY_W-1:0] == KEY_ADDR_B);
      nxt    = state;
      hit    = 1'b0;
      hit_op = OP_READ;
      id_set = 1'b0;
      if (seq_we) begin
         nxt = SQ_IDLE;
         if (state != SQ_PD && wr_data == K_RESET) begin
            hit    = !restricted;
            hit_op = OP_READ;
         end else begin
            case (state)
               SQ_IDLE: begin
                  if (wr_data == K_KEY_A && at_a) nxt = SQ_U1;
                  else if (restricted && wr_data == K_RESUME) begin
                     hit    = 1'b1;
                     hit_op = OP_RESUME;
                  end
               end
               SQ_U1: if (wr_data == K_KEY_B && at_b) nxt = SQ_U2;
               SQ_U2: begin
                  if (at_a && wr_data == K_PROG) nxt = SQ_PD;
                  else if (at_a && !restricted && wr_data == K_ERASE) nxt = SQ_E0;
                  else if (at_a && !restricted && wr_data == K_IDENT) begin
                     hit    = 1'b1;
                     hit_op = OP_ID;
                     id_set = 1'b1;
                  end
               end
               SQ_PD: begin
                  hit    = 1'b1;
                  hit_op = OP_PROG;
               end
               SQ_E0: if (wr_data == K_KEY_A && at_a) nxt = SQ_E1;
               SQ_E1: if (wr_data == K_KEY_B && at_b) nxt = SQ_E2;
               SQ_E2: begin
                  if (wr_data == K_SECTOR) begin
                     hit    = 1'b1;
                     hit_op = OP_SECT_ERASE;
                  end else if (at_a && wr_data == K_CHIP) begin
                     hit    = 1'b1;
                     hit_op = OP_CHIP_ERASE;
                  end else if (at_a && wr_data == K_PROTECT) begin
                     hit    = 1'b1;
                     hit_op = OP_UNLOCK;
                  end
               end
               default: nxt = SQ_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         id_mode <= 1'b0;
      end else begin
         state <= nxt;
         if (seq_we) id_mode <= id_set;
      end
   end

   // R12: no erase or ID path can open while suspended
   a_r12_no_erase_in_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      (restricted && state == SQ_U2) |=> (state != SQ_E0));
endmodule

// File: rtl/fcd_id_mux.sv
module fcd_id_mux
   import fcd_pkg::*;
#(
   parameter bit BOTTOM_BOOT = 1'b0
) (
   input  logic              id_mode,
   input  logic [1:0]        rd_addr,
   output logic [BYTE_W-1:0] id_data
);
   logic [BYTE_W-1:0] dev_code;

   generate
      if (BOTTOM_BOOT) begin : g_bottom
         assign dev_code = ID_DEV_BOT;
      end else begin : g_top
         assign dev_code = ID_DEV_TOP;
      end
   endgenerate

   always_comb begin
      id_data = '0;
      if (id_mode && !rd_addr[1]) id_data = rd_addr[0] ? dev_code : ID_MAKER;
   end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import fcd_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter bit BOTTOM_BOOT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              prog_busy,
   input  logic              erase_busy,
   input  logic              suspended,
   input  logic [1:0]        rd_addr,
   output logic              req_valid,
   output logic [2:0]        req_op,
   output logic [ADDR_W-1:0] req_addr,
   output logic [7:0]        req_data,
   output logic              id_active,
   output logic [7:0]        id_data
);
   localparam int SPARE_W = ADDR_W - KEY_W;

   generate
      if (SPARE_W < 0) begin : g_bad_addr_w
         $error("ADDR_W must cover the key address field");
      end
   endgenerate

   logic seq_we, susp_fire, restricted, seq_hit;
   op_e  seq_op;

   fcd_gate u_gate (
      .wr_en      (wr_en),
      .wr_data    (wr_data),
      .prog_busy  (prog_busy),
      .erase_busy (erase_busy),
      .suspended  (suspended),
      .seq_we     (seq_we),
      .susp_fire  (susp_fire),
      .restricted (restricted)
   );

   fcd_sequencer #(.ADDR_W(ADDR_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .seq_we     (seq_we),
      .restricted (restricted),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .hit        (seq_hit),
      .hit_op     (seq_op),
      .id_mode    (id_active)
   );

   fcd_id_mux #(.BOTTOM_BOOT(BOTTOM_BOOT)) u_idmux (
      .id_mode (id_active),
      .rd_addr (rd_addr),
      .id_data (id_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_op    <= OP_READ;
         req_addr  <= '0;
         req_data  <= '0;
      end else begin
         req_valid <= seq_hit || susp_fire;
         req_op    <= susp_fire ? OP_SUSPEND : seq_op;
         if (wr_en) begin
            req_addr <= wr_addr;
            req_data <= wr_data;
         end
      end
   end

   a_r13_pulse_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $past(wr_en));
   a_r9_prog_busy_silent: assert property (@(posedge clk) disable iff (!rst_n)
      prog_busy |=> !req_valid);
   a_r10_erase_only_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_busy && !prog_busy) |=> (!req_valid || req_op == OP_SUSPEND));
   a_r11_resume_needs_suspend: assert property (@(posedge clk) disable iff (!rst_n)
      !suspended |=> !(req_valid && req_op == OP_RESUME));
   a_r3_prog_payload: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_PROG) |-> (req_addr == $past(wr_addr) && req_data == $past(wr_data)));
   a_r4_id_with_request: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(id_active) |-> (req_valid && req_op == OP_ID));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
   import fcd_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [18:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        prog_busy = 1'b0, erase_busy = 1'b0, suspended = 1'b0;
   logic [1:0]  rd_addr = '0;
   logic        req_valid, id_active;
   logic [2:0]  req_op;
   logic [18:0] req_addr;
   logic [7:0]  req_data, id_data;

   int n_chk = 0, n_fail = 0;
   logic        got_v;
   logic [2:0]  got_op;
   logic [18:0] got_a;
   logic [7:0]  got_d;

   always #2 clk = ~clk;

   flash_cmd_decoder u_flash_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .prog_busy(prog_busy), .erase_busy(erase_busy), .suspended(suspended),
      .rd_addr(rd_addr), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .req_data(req_data), .id_active(id_active), .id_data(id_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [18:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      got_v = req_valid; got_op = req_op; got_a = req_addr; got_d = req_data;
   endtask

   task automatic keys(input logic [18:0] hi);
      wr(hi | 19'h555, 8'hAA);
      wr(hi | 19'h2AA, 8'h55);
   endtask

   task automatic t_reset;
      chk("R1 req_valid", req_valid, 0);
      chk("R1 id_active", id_active, 0);
      chk("R1 id_data", id_data, 0);
   endtask

   task automatic t_program;
      keys(19'h7D000);
      wr(19'h3C555, 8'hA0);
      chk("R2 no early request", got_v, 0);
      wr(19'h4ABCD, 8'h5A);
      chk("R3 valid", got_v, 1);
      chk("R3 op", got_op, OP_PROG);
      chk("R3 addr", got_a, 19'h4ABCD);
      chk("R3 data", got_d, 8'h5A);
      @(negedge clk);
      chk("R13 single cycle", req_valid, 0);
      keys(0); wr(19'h555, 8'hA0); wr(19'h00010, 8'hF0);
      chk("R3 F0 as data op", got_op, OP_PROG);
      chk("R3 F0 as data", got_d, 8'hF0);
   endtask

   task automatic t_ident;
      keys(0); wr(19'h555, 8'h90);
      chk("R4 op", got_op, OP_ID);
      chk("R4 valid", got_v, 1);
      chk("R4 flag", id_active, 1);
      rd_addr = 2'd0; #1 chk("R4 maker", id_data, 8'hC2);
      rd_addr = 2'd1; #1 chk("R4 device", id_data, 8'h45);
      rd_addr = 2'd2; #1 chk("R4 upper", id_data, 8'h00);
      rd_addr = 2'd0;
      wr(19'h555, 8'hAA);
      chk("R4 cleared", id_active, 0);
      wr(19'h2AA, 8'h55); wr(19'h555, 8'hF0);
   endtask

   task automatic t_chip;
      keys(0); wr(19'h555, 8'h80); keys(0); wr(19'h555, 8'h10);
      chk("R5 chip valid", got_v, 1);
      chk("R5 chip op", got_op, OP_CHIP_ERASE);
      keys(0); wr(19'h555, 8'h80); keys(0); wr(19'h555, 8'h20);
      chk("R5 unlock op", got_op, OP_UNLOCK);
   endtask

   task automatic t_sector;
      keys(0); wr(19'h555, 8'h80); keys(0); wr(19'h61234, 8'h30);
      chk("R6 valid", got_v, 1);
      chk("R6 op", got_op, OP_SECT_ERASE);
      chk("R6 addr", got_a, 19'h61234);
   endtask

   task automatic t_reset_cmd;
      wr(19'h555, 8'hAA); wr(19'h1234, 8'hF0);
      chk("R7 valid", got_v, 1);
      chk("R7 op", got_op, OP_READ);
      wr(19'h2AA, 8'h55); wr(19'h555, 8'hA0); wr(19'h100, 8'h11);
      chk("R7 sequence restarted", got_v, 0);
   endtask

   task automatic t_wrong;
      wr(19'h555, 8'hAA); wr(19'h2AB, 8'h55);
      chk("R8 bad key addr", got_v, 0);
      wr(19'h555, 8'h90);
      chk("R8 treated as first", got_v, 0);
      chk("R8 no id", id_active, 0);
      keys(0); wr(19'h555, 8'h90);
      chk("R8 recovers", got_op, OP_ID);
      wr(19'h0, 8'hF0);
   endtask

   task automatic t_prog_busy;
      wr(19'h555, 8'hAA);
      @(negedge clk) prog_busy = 1'b1;
      wr(19'h0, 8'hF0);
      chk("R9 F0 ignored", got_v, 0);
      wr(19'h2AA, 8'h55); wr(19'h555, 8'h90);
      chk("R9 seq ignored", got_v, 0);
      @(negedge clk) prog_busy = 1'b0;
      wr(19'h2AA, 8'h55); wr(19'h555, 8'hA0); wr(19'h7, 8'h3C);
      chk("R9 state kept", got_op, OP_PROG);
      chk("R9 state kept valid", got_v, 1);
   endtask

   task automatic t_erase_busy;
      @(negedge clk) erase_busy = 1'b1;
      wr(19'h0, 8'hF0);
      chk("R10 F0 ignored", got_v, 0);
      wr(19'h555, 8'h30);
      chk("R10 30 ignored", got_v, 0);
      wr(19'h4321, 8'hB0);
      chk("R10 suspend valid", got_v, 1);
      chk("R10 suspend op", got_op, OP_SUSPEND);
      @(negedge clk) erase_busy = 1'b0;
   endtask

   task automatic t_stray;
      wr(19'h10, 8'hB0);
      chk("R11 stray suspend", got_v, 0);
      wr(19'h10, 8'h30);
      chk("R11 stray resume", got_v, 0);
   endtask

   task automatic t_suspended;
      @(negedge clk) suspended = 1'b1;
      wr(19'h0, 8'hF0);
      chk("R12 F0 silent", got_v, 0);
      keys(0); wr(19'h555, 8'h80); keys(0); wr(19'h555, 8'h10);
      chk("R12 erase dropped", got_v, 0);
      keys(0); wr(19'h555, 8'h90);
      chk("R12 id dropped", got_v, 0);
      chk("R12 id flag", id_active, 0);
      keys(0); wr(19'h555, 8'hA0); wr(19'h22222, 8'h99);
      chk("R12 program op", got_op, OP_PROG);
      chk("R12 program valid", got_v, 1);
      wr(19'h5, 8'h30);
      chk("R12 resume valid", got_v, 1);
      chk("R12 resume op", got_op, OP_RESUME);
      @(negedge clk) suspended = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_program;
      t_ident;
      t_chip;
      t_sector;
      t_reset_cmd;
      t_wrong;
      t_prog_busy;
      t_erase_busy;
      t_stray;
      t_suspended;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule